// File: doc/BRIEF.md
# Three-Byte Interrupt Aggregator

The block collects twenty-four single-bit event inputs into three sticky status bytes and raises one level interrupt toward a host. Each source has two independent mask bits. The status-mask bit decides whether an event is recorded at all. The line-mask bit decides whether a recorded event can drive the interrupt output.

The host reaches all nine register bytes through a byte-wide port. A start strobe loads an address pointer. Each read or write strobe then moves the pointer one place forward, so multi-byte bursts walk the map in order. After servicing, the host writes any byte to any status address, and that single write clears all twenty-four status bits together.

The map is as follows. Addresses 0 to 2 hold status bytes A to C. Addresses 3 to 5 hold the line-mask bytes. Addresses 6 to 8 hold the status-mask bytes. Byte k of each group covers sources 8k to 8k+7.

Top module: `irq_gather`

## Requirements
- R1: Source n (0 to 23) is recorded in the status byte at address n/8, bit n%8, so status A holds sources 0 to 7.
- R2: An event on a source sets its status bit only when that source's status-mask bit is 0. A set bit stays set until a clear.
- R3: Source positions 12 and 23 are reserved. Their status bits always read 0, whatever the source inputs or masks.
- R4: A write of any data value to address 0, 1 or 2 clears all 24 status bits on that clock edge.
- R5: An event that arrives in the same cycle as a clearing write is recorded, and its status bit reads 1 after that edge.
- R6: irq_out is 1 exactly when some status bit is 1 and its line-mask bit is 0.
- R7: After reset, all status bytes read 0x00, all six mask bytes read 0xFF, irq_out is 0 and the pointer is 0.
- R8: The line-mask bytes (addresses 3 to 5) and status-mask bytes (addresses 6 to 8) are fully readable and writable. Clearing the status does not alter them.
- R9: acc_start loads the pointer from acc_addr, and an address above 8 loads 0. Each cycle with wr_en or rd_en moves the pointer to the next address, and address 8 is followed by address 0.
- R10: Reading a register has no side effect on any register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 24 | Event inputs, one per source, sampled every cycle |
| acc_start | input | 1 | Load the pointer from acc_addr; strobes are ignored in this cycle |
| acc_addr | input | 4 | Start address of an access |
| wr_en | input | 1 | Write bus_wdata at the pointer, then advance |
| bus_wdata | input | 8 | Write data |
| rd_en | input | 1 | Acknowledge a read of bus_rdata, then advance |
| bus_rdata | output | 8 | Byte at the current pointer, combinational |
| irq_out | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that the event inputs, strobes and data are driven to known values from reset onward. They also assume that acc_start takes priority over wr_en and rd_en in the same cycle. Otherwise their first-cycle $past terms would see undefined values. The bench keeps to this by holding every input at zero through reset and by changing inputs only on the falling edge. The behavioural reference model therefore sees the same stable values that the design samples. The assertion on newly set status bits takes for granted that any bit which appears was enabled by the status mask in the cycle before, which covers both the same-cycle clear case and the sticky case.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int BYTES = 3,
  parameter logic [8*BYTES-1:0] RSV_BITS = 24'h80_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8*BYTES-1:0] src_evt,
  input  logic              acc_start,
  input  logic [$clog2(3*BYTES)-1:0] acc_addr,
  input  logic              wr_en,
  input  logic [7:0]        bus_wdata,
  input  logic              rd_en,
  output logic [7:0]        bus_rdata,
  output logic              irq_out
);
  localparam int NSRC = 8 * BYTES;
  localparam int NREG = 3 * BYTES;
  localparam int PW   = $clog2(NREG);
  localparam logic [PW-1:0] LAST   = PW'(NREG - 1);
  localparam logic [PW-1:0] LM_BASE = PW'(BYTES);
  localparam logic [PW-1:0] SM_BASE = PW'(2 * BYTES);

  logic [NSRC-1:0] stat, lmask, smask;
  logic [PW-1:0]   ptr, ptr_nxt, off;
  logic            in_stat, in_lm, do_wr, clr;

  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign in_stat = ptr < LM_BASE;
  assign in_lm   = !in_stat && ptr < SM_BASE;
  assign off     = in_stat ? ptr : (in_lm ? ptr - LM_BASE : ptr - SM_BASE);
  assign do_wr   = wr_en && !acc_start;
  assign clr     = do_wr && in_stat;

  always_comb begin
    if (in_stat)    bus_rdata = stat[8*off +: 8];
    else if (in_lm) bus_rdata = lmask[8*off +: 8];
    else            bus_rdata = smask[8*off +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr <= '0;
    else if (acc_start)        ptr <= (acc_addr > LAST) ? '0 : acc_addr;
    else if (wr_en || rd_en)   ptr <= ptr_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= ((clr ? '0 : stat) | (src_evt & ~smask)) & ~RSV_BITS;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lmask[8*k +: 8] <= 8'hFF;
        smask[8*k +: 8] <= 8'hFF;
      end else if (do_wr) begin
        if (ptr == LM_BASE + PW'(k)) lmask[8*k +: 8] <= bus_wdata;
        if (ptr == SM_BASE + PW'(k)) smask[8*k +: 8] <= bus_wdata;
      end
    end
  end

  assign irq_out = |(stat & ~lmask);
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int BYTES = 3,
  parameter logic [8*BYTES-1:0] RSV_BITS = 24'h80_1000,
  parameter int PW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [8*BYTES-1:0] src_evt,
  input logic              acc_start,
  input logic              wr_en,
  input logic              irq_out,
  input logic [8*BYTES-1:0] stat,
  input logic [8*BYTES-1:0] lmask,
  input logic [8*BYTES-1:0] smask,
  input logic [PW-1:0]     ptr
);
  localparam int NREG = 3 * BYTES;
  logic clear_wr;
  assign clear_wr = wr_en && !acc_start && (ptr < PW'(BYTES));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_wr && src_evt == '0) |=> stat == '0);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_wr |=> (stat & $past(stat)) == $past(stat));
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) & $past(smask)) == '0);
  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & RSV_BITS) == '0);
  assert_line_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lmask == '1) |-> !irq_out);
  assert_irq_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> stat != '0);
  assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(NREG));
endmodule

bind irq_gather irq_gather_chk #(.BYTES(BYTES), .RSV_BITS(RSV_BITS), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .acc_start(acc_start),
  .wr_en(wr_en), .irq_out(irq_out), .stat(stat), .lmask(lmask),
  .smask(smask), .ptr(ptr)
);

// File: tb/irq_gather_test.sv
`timescale 1ns/1ps
module irq_gather_test;
  logic clk = 0, rst_n = 0;
  logic [23:0] src_evt = '0;
  logic acc_start = 0, wr_en = 0, rd_en = 0;
  logic [3:0] acc_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_out;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  irq_gather uut (.clk(clk), .rst_n(rst_n), .src_evt(src_evt), .acc_start(acc_start),
    .acc_addr(acc_addr), .wr_en(wr_en), .bus_wdata(bus_wdata), .rd_en(rd_en),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  // behavioural reference: registers as byte arrays
  byte unsigned m_reg[9];
  int m_ptr;

  function automatic byte unsigned exp_rd();
    return m_reg[m_ptr];
  endfunction

  function automatic bit exp_irq();
    for (int i = 0; i < 3; i++) if ((m_reg[i] & ~m_reg[3+i]) != 0) return 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) m_reg[i] = (i < 3) ? 8'h00 : 8'hFF;
      m_ptr = 0;
    end else begin
      byte unsigned nst[3];
      bit clr;
      clr = wr_en && !acc_start && m_ptr < 3;
      for (int i = 0; i < 3; i++) begin
        nst[i] = clr ? 8'h00 : m_reg[i];
        for (int b = 0; b < 8; b++) begin
          int s;
          s = 8*i + b;
          if (src_evt[s] && !m_reg[6+i][b] && s != 12 && s != 23) nst[i][b] = 1'b1;
        end
      end
      if (wr_en && !acc_start && m_ptr >= 3) m_reg[m_ptr] = bus_wdata;
      for (int i = 0; i < 3; i++) m_reg[i] = nst[i];
      if (acc_start) m_ptr = (acc_addr > 8) ? 0 : int'(acc_addr);
      else if (wr_en || rd_en) m_ptr = (m_ptr == 8) ? 0 : m_ptr + 1;
    end
    #1;
    if (rst_n && !finished) begin
      check("R6 irq_out", int'(irq_out), int'(exp_irq()));
      check(m_ptr < 3 ? "R1 status byte" : "R8 mask byte", int'(bus_rdata), int'(exp_rd()));
    end
  end

  task automatic start_at(int a);
    @(negedge clk); acc_start = 1; acc_addr = 4'(a);
    @(posedge clk); #1 acc_start = 0;
  endtask
  task automatic wr(byte unsigned d);
    @(negedge clk); wr_en = 1; bus_wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic rd(output byte unsigned d);
    @(negedge clk); rd_en = 1; #1 d = bus_rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask
  task automatic pulse(logic [23:0] m);
    @(negedge clk); src_evt = m;
    @(posedge clk); #1 src_evt = '0;
  endtask

  initial begin
    byte unsigned d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R7 irq after reset", int'(irq_out), 0);
    start_at(0);
    for (int i = 0; i < 9; i++) begin
      rd(d); check("R7 reset value", d, i < 3 ? 8'h00 : 8'hFF);
    end
    rd(d); check("R9 wrap after 8", d, 8'h00);

    start_at(6); wr(8'h00); wr(8'h00); wr(8'h00);
    pulse(24'h10_0201);
    rd(d); check("R9 burst wrapped to status A", d, 8'h01);
    rd(d); check("R1 status B", d, 8'h02);
    rd(d); check("R1 status C", d, 8'h10);
    check("R6 irq masked by line mask", int'(irq_out), 0);

    start_at(4); wr(8'hFD);
    #1 check("R6 irq unmasked source 9", int'(irq_out), 1);

    pulse(24'h80_1000);
    start_at(1); rd(d); check("R3 reserved bit 12", d, 8'h02);
    rd(d); check("R3 reserved bit 23", d, 8'h10);

    start_at(6); wr(8'hFF);
    pulse(24'h00_0002);
    start_at(0); rd(d); check("R2 status mask blocks", d, 8'h01);
    start_at(0); rd(d); check("R10 read repeat", d, 8'h01);
    repeat (5) @(posedge clk);
    start_at(0); rd(d); check("R2 sticky", d, 8'h01);

    start_at(2); wr(8'h5A);
    start_at(0);
    for (int i = 0; i < 3; i++) begin rd(d); check("R4 clear all", d, 8'h00); end
    check("R4 irq after clear", int'(irq_out), 0);
    rd(d); check("R8 line mask kept", d, 8'hFF);
    rd(d); check("R8 line mask kept", d, 8'hFD);

    start_at(1);
    @(negedge clk); wr_en = 1; bus_wdata = 8'h00; src_evt = 24'h02_0000;
    @(posedge clk); #1 wr_en = 0; src_evt = '0;
    start_at(2); rd(d); check("R5 event beats clear", d, 8'h02);

    start_at(5); wr(8'hA5);
    start_at(5); rd(d); check("R8 mask readback", d, 8'hA5);
    start_at(12); rd(d); check("R9 out of range start", d, 8'h00);
    start_at(8); rd(d); check("R8 status mask C", d, 8'h00);
    rd(d); check("R9 wrap 8 to 0", d, 8'h00);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule